// File: doc/BRIEF.md
# Reset and Clock Bring-up Sequencer

This block decides the reset and clock-enable state of a chip with several clock domains. Three events can reset the chip: power-up, loss of the power-good signal, and a watchdog expiry. Any of them returns every domain to one fixed default. In that default the chip is in normal power mode, pads are safe, and only the processor domain leaves reset by itself. The master PLL reset follows power-up alone, so the two lighter reset sources leave the master clock running.

When the processor comes out of reset, it brings up the rest of the chip through a small register port. The usual order is:

1. Power up the secondary PLL while its divider logic is still held in reset.
2. Wait until the lock indication can be seen.
3. Release the divider, which starts every derived display clock.
4. Release the external reset outputs as the last step.

Real PLLs, dividers and pads are not modelled. They are represented by enable, power-down and output-enable signals.

Top module: `bringup_seq`

## Requirements
- R1: When `por_n` is low, `master_pll_rst` is 1 and `proc_rst_n` is 0. `master_pll_rst` stays at 1 for POR_HOLD (8) clocks after `por_n` rises. After that, STATUS[2:0] (address 4) reads 3'b001.
- R2: A power-good loss (`pgood` low) or a one-cycle `wdt_expire` pulse does not assert `master_pll_rst`. Either one returns all other state to its default.
- R3: `proc_rst_n` is released REL_DELAY (4) clocks after the last reset source ends, with no software action. `dom_rst_n`, `ext_rst_n` and `fe_clk_en` stay all-zero until software writes them.
- R4: The default state is `proc_clk_full`=1, `low_power`=0, `pll2_pd`=1, `div_rst`=1 and `dclk_en`=0.
- R5: The default pad state is `gpio_oe`=0 (tri-stated), `disp_en_oe`=0 (tri-stated) and `disp_force_low`=1.
- R6: Writing PLL control (address 0) with bit0=1 and bit1=0 clears `pll2_pd` on the next clock, while `div_rst` stays at 1.
- R7: Writing address 0 with bit0=1 and bit1=1 while the synchronized lock is high clears `div_rst` and sets every bit of `dclk_en`. The read of address 0 then returns bit1=1 (running) and bit0=1 (PLL on).
- R8: A divider-release write made without lock, or with the PLL off, is ignored. It sets the sticky STATUS bit3, which only a reset clears.
- R9: If `pll_lock` falls while the divider runs, `dclk_en` goes to 0 and `div_rst` goes to 1 within SYNC_STAGES+1 clocks. `pll2_pd` stays at 0.
- R10: The following registers read back what was written: domain release (address 1), front-end clock enable (address 2), external release (address 3), clock config (address 5: bit0 slows the processor clock, bit1 selects low power) and pad control (address 6: bits[5:0] `gpio_oe`, bit6 `disp_en_oe`, bit7 clears `disp_force_low`). Writes made while `proc_rst_n` is 0 are ignored.
- R11: STATUS[2:0] holds the cause of the last reset as a one-hot code: 001 for power-up, 010 for power-good loss, 100 for watchdog. Power-good loss wins over a watchdog in the same cycle. STATUS[4] shows the synchronized lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| por_n | input | 1 | Power-up reset, active low, asynchronous |
| pgood | input | 1 | Power-good level; low means loss |
| wdt_expire | input | 1 | Watchdog expiry pulse, synchronous |
| pll_lock | input | 1 | Secondary PLL lock indication, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Read data, registered one clock after `rd_addr` |
| master_pll_rst | output | 1 | Master PLL reset, active high |
| proc_rst_n | output | 1 | Processor domain reset, active low |
| dom_rst_n | output | 4 | Other domain resets, active low |
| fe_clk_en | output | 3 | Front-end derived clock enables |
| proc_clk_full | output | 1 | Processor clock at full rate |
| low_power | output | 1 | Low power mode select |
| pll2_pd | output | 1 | Secondary PLL power-down |
| div_rst | output | 1 | Secondary divider reset, active high |
| dclk_en | output | 3 | Derived display clock enables |
| ext_rst_n | output | 2 | External reset outputs, active low |
| gpio_oe | output | 6 | General-purpose pad output enables |
| disp_en_oe | output | 1 | Display output-enable pad drive enable |
| disp_force_low | output | 1 | Forces the display data pads low |

## Verification
A soft reset that fails to clear a register shows up one clock after the reset edge: an enable or release output is still high next to a `proc_rst_n` of 0. A divider state that is wrong shows up within one clock as a disagreement between `div_rst`, `dclk_en`, `pll2_pd` and the running bit of address 0. A missed lock loss keeps `dclk_en` high for longer than SYNC_STAGES+1 clocks. A cause latch that is wrong is only seen when STATUS is read, so the bench reads STATUS after every kind of reset.

// File: rtl/bringup_pkg.sv
package bringup_pkg;

  localparam int unsigned A_PLL  = 0;
  localparam int unsigned A_DOM  = 1;
  localparam int unsigned A_FE   = 2;
  localparam int unsigned A_EXT  = 3;
  localparam int unsigned A_STAT = 4;
  localparam int unsigned A_CLK  = 5;
  localparam int unsigned A_PAD  = 6;

  typedef enum logic {DIV_HELD = 1'b0, DIV_RUN = 1'b1} div_state_e;

  // Divider may start only with the PLL powered and lock observed.
  function automatic logic release_allowed(input logic pll_on, input logic lock_s);
    return pll_on & lock_s;
  endfunction

  // One-hot reset cause; power-up outranks power-good loss, which outranks watchdog.
  function automatic logic [2:0] cause_code(input logic por, input logic pg_lost,
                                            input logic wdt);
    if (por)          return 3'b001;
    else if (pg_lost) return 3'b010;
    else if (wdt)     return 3'b100;
    else              return 3'b000;
  endfunction

endpackage

// File: rtl/bringup_rst_ctl.sv
module bringup_rst_ctl
  import bringup_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned POR_HOLD    = 8,
  parameter int unsigned REL_DELAY   = 4
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       pgood,
  input  logic       wdt_expire,
  output logic       arst_n,
  output logic       master_pll_rst,
  output logic       sys_rst,
  output logic       proc_rst_n,
  output logic [2:0] cause
);
  localparam int unsigned PW = $clog2(POR_HOLD + 1);
  localparam int unsigned RW = $clog2(REL_DELAY + 1);

  logic [SYNC_STAGES-1:0] por_sync;
  logic [SYNC_STAGES-1:0] pg_sync;
  logic [PW-1:0]          por_cnt;
  logic [RW-1:0]          rel_cnt;
  logic                   pg_lost;
  logic                   soft_rst;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) por_sync <= '0;
    else        por_sync <= {por_sync[SYNC_STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) pg_sync <= '1;
    else        pg_sync <= {pg_sync[SYNC_STAGES-2:0], pgood};

  assign arst_n  = por_sync[SYNC_STAGES-1];
  assign pg_lost = !pg_sync[SYNC_STAGES-1];

  // Master PLL held for POR_HOLD clocks after power-up only.
  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                       por_cnt <= '0;
    else if (por_cnt != PW'(POR_HOLD)) por_cnt <= por_cnt + 1'b1;

  assign master_pll_rst = (por_cnt != PW'(POR_HOLD));
  assign soft_rst       = pg_lost | wdt_expire;
  assign sys_rst        = master_pll_rst | soft_rst;

  // Processor domain is released automatically after a quiet window.
  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                         rel_cnt <= '0;
    else if (sys_rst)                   rel_cnt <= '0;
    else if (rel_cnt != RW'(REL_DELAY)) rel_cnt <= rel_cnt + 1'b1;

  assign proc_rst_n = (rel_cnt == RW'(REL_DELAY));

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)        cause <= cause_code(1'b1, 1'b0, 1'b0);
    else if (soft_rst) cause <= cause_code(1'b0, pg_lost, wdt_expire);

  assert_proc_held_R1: assert property (@(posedge clk) disable iff (!arst_n)
    master_pll_rst |-> !proc_rst_n);
  assert_soft_holds_proc_R2: assert property (@(posedge clk) disable iff (!arst_n)
    soft_rst |=> !proc_rst_n);
  assert_cause_onehot_R11: assert property (@(posedge clk) disable iff (!arst_n)
    $countones(cause) == 1);
  assert_pg_cause_R11: assert property (@(posedge clk) disable iff (!arst_n)
    pg_lost |=> cause == 3'b010);
  assert_wdt_cause_R11: assert property (@(posedge clk) disable iff (!arst_n)
    (wdt_expire && !pg_lost) |=> cause == 3'b100);
  assert_release_R3: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(proc_rst_n) |-> !sys_rst && $past(!sys_rst));

endmodule

// File: rtl/bringup_pll_dom.sv
module bringup_pll_dom
  import bringup_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned N_DCLK      = 3
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              sys_rst,
  input  logic              pll_on,
  input  logic              req_vld,
  input  logic              req_on,
  input  logic              req_rel,
  input  logic              pll_lock,
  output logic              pll_pd,
  output logic              div_rst,
  output logic [N_DCLK-1:0] dclk_en,
  output logic              running,
  output logic              lock_s,
  output logic              lock_err
);
  logic [SYNC_STAGES-1:0] lock_sync;
  div_state_e             state, state_nxt;
  logic                   rel_ok;
  logic                   rel_reject;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) lock_sync <= '0;
    else         lock_sync <= {lock_sync[SYNC_STAGES-2:0], pll_lock};

  assign lock_s     = lock_sync[SYNC_STAGES-1];
  assign running    = (state == DIV_RUN);
  assign rel_ok     = release_allowed(pll_on & req_on, lock_s);
  assign rel_reject = req_vld && req_rel && !running && !rel_ok;

  always_comb begin
    state_nxt = state;
    case (state)
      DIV_HELD: if (req_vld && req_rel && rel_ok) state_nxt = DIV_RUN;
      DIV_RUN:  if (!pll_on || !lock_s || (req_vld && (!req_rel || !req_on)))
                  state_nxt = DIV_HELD;
      default:  state_nxt = DIV_HELD;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) begin
      state    <= DIV_HELD;
      lock_err <= 1'b0;
    end else if (sys_rst) begin
      state    <= DIV_HELD;
      lock_err <= 1'b0;
    end else begin
      state <= state_nxt;
      if (rel_reject) lock_err <= 1'b1;
    end

  assign pll_pd  = !pll_on;
  assign div_rst = !running;

  for (genvar g = 0; g < N_DCLK; g++) begin : g_dclk
    assign dclk_en[g] = running;
  end

  assert_run_powered_R6: assert property (@(posedge clk) disable iff (!arst_n)
    running |-> !pll_pd);
  assert_run_after_lock_R7: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(running) |-> $past(lock_s));
  assert_reject_R8: assert property (@(posedge clk) disable iff (!arst_n)
    (rel_reject && !sys_rst) |=> !running && lock_err);
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!arst_n)
    (lock_err && !sys_rst) |=> lock_err);
  assert_lock_drop_R9: assert property (@(posedge clk) disable iff (!arst_n)
    (running && !lock_s) |=> !running && !pll_pd);

endmodule

// File: rtl/bringup_regs.sv
module bringup_regs
  import bringup_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned N_DOM  = 4,
  parameter int unsigned N_FE   = 3,
  parameter int unsigned N_EXT  = 2,
  parameter int unsigned N_GPIO = 6
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              sys_rst,
  input  logic              wr_allow,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [2:0]        cause,
  input  logic              lock_err,
  input  logic              lock_s,
  input  logic              running,
  output logic              pll_on,
  output logic              req_vld,
  output logic              req_on,
  output logic              req_rel,
  output logic [N_DOM-1:0]  dom_rel,
  output logic [N_FE-1:0]   fe_en,
  output logic [N_EXT-1:0]  ext_rel,
  output logic [1:0]        clk_cfg,
  output logic [N_GPIO+1:0] pad_ctl,
  output logic [DATA_W-1:0] rd_data
);
  logic we;

  assign we      = wr_en && wr_allow;
  assign req_vld = we && (wr_addr == ADDR_W'(A_PLL));
  assign req_on  = wr_data[0];
  assign req_rel = wr_data[1];

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) begin
      pll_on  <= 1'b0;
      dom_rel <= '0;
      fe_en   <= '0;
      ext_rel <= '0;
      clk_cfg <= '0;
      pad_ctl <= '0;
    end else if (sys_rst) begin
      pll_on  <= 1'b0;
      dom_rel <= '0;
      fe_en   <= '0;
      ext_rel <= '0;
      clk_cfg <= '0;
      pad_ctl <= '0;
    end else if (we) begin
      case (wr_addr)
        ADDR_W'(A_PLL): pll_on  <= wr_data[0];
        ADDR_W'(A_DOM): dom_rel <= wr_data[N_DOM-1:0];
        ADDR_W'(A_FE):  fe_en   <= wr_data[N_FE-1:0];
        ADDR_W'(A_EXT): ext_rel <= wr_data[N_EXT-1:0];
        ADDR_W'(A_CLK): clk_cfg <= wr_data[1:0];
        ADDR_W'(A_PAD): pad_ctl <= wr_data[N_GPIO+1:0];
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) rd_data <= '0;
    else begin
      case (rd_addr)
        ADDR_W'(A_PLL):  rd_data <= DATA_W'({running, pll_on});
        ADDR_W'(A_DOM):  rd_data <= DATA_W'(dom_rel);
        ADDR_W'(A_FE):   rd_data <= DATA_W'(fe_en);
        ADDR_W'(A_EXT):  rd_data <= DATA_W'(ext_rel);
        ADDR_W'(A_STAT): rd_data <= DATA_W'({lock_s, lock_err, cause});
        ADDR_W'(A_CLK):  rd_data <= DATA_W'(clk_cfg);
        ADDR_W'(A_PAD):  rd_data <= DATA_W'(pad_ctl);
        default:         rd_data <= '0;
      endcase
    end

  assert_soft_clear_R3: assert property (@(posedge clk) disable iff (!arst_n)
    sys_rst |=> (dom_rel == '0) && (ext_rel == '0) && (fe_en == '0) && (pad_ctl == '0)
                && (clk_cfg == '0) && !pll_on);
  assert_locked_out_R10: assert property (@(posedge clk) disable iff (!arst_n)
    (wr_en && !wr_allow && !sys_rst) |=> $stable(dom_rel) && $stable(ext_rel)
                && $stable(fe_en) && $stable(pad_ctl) && $stable(pll_on));

endmodule

// File: rtl/bringup_seq.sv
module bringup_seq
  import bringup_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned POR_HOLD    = 8,
  parameter int unsigned REL_DELAY   = 4,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned N_DOM       = 4,
  parameter int unsigned N_FE        = 3,
  parameter int unsigned N_DCLK      = 3,
  parameter int unsigned N_EXT       = 2,
  parameter int unsigned N_GPIO      = 6
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              pgood,
  input  logic              wdt_expire,
  input  logic              pll_lock,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              master_pll_rst,
  output logic              proc_rst_n,
  output logic [N_DOM-1:0]  dom_rst_n,
  output logic [N_FE-1:0]   fe_clk_en,
  output logic              proc_clk_full,
  output logic              low_power,
  output logic              pll2_pd,
  output logic              div_rst,
  output logic [N_DCLK-1:0] dclk_en,
  output logic [N_EXT-1:0]  ext_rst_n,
  output logic [N_GPIO-1:0] gpio_oe,
  output logic              disp_en_oe,
  output logic              disp_force_low
);
  logic              arst_n, sys_rst;
  logic [2:0]        cause;
  logic              pll_on, req_vld, req_on, req_rel;
  logic              running, lock_s, lock_err;
  logic [N_DOM-1:0]  dom_rel;
  logic [N_EXT-1:0]  ext_rel;
  logic [1:0]        clk_cfg;
  logic [N_GPIO+1:0] pad_ctl;

  bringup_rst_ctl #(
    .SYNC_STAGES(SYNC_STAGES), .POR_HOLD(POR_HOLD), .REL_DELAY(REL_DELAY)
  ) u_rst (
    .clk(clk), .por_n(por_n), .pgood(pgood), .wdt_expire(wdt_expire),
    .arst_n(arst_n), .master_pll_rst(master_pll_rst), .sys_rst(sys_rst),
    .proc_rst_n(proc_rst_n), .cause(cause)
  );

  bringup_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_DOM(N_DOM), .N_FE(N_FE),
    .N_EXT(N_EXT), .N_GPIO(N_GPIO)
  ) u_regs (
    .clk(clk), .arst_n(arst_n), .sys_rst(sys_rst), .wr_allow(proc_rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .cause(cause), .lock_err(lock_err), .lock_s(lock_s), .running(running),
    .pll_on(pll_on), .req_vld(req_vld), .req_on(req_on), .req_rel(req_rel),
    .dom_rel(dom_rel), .fe_en(fe_clk_en), .ext_rel(ext_rel), .clk_cfg(clk_cfg),
    .pad_ctl(pad_ctl), .rd_data(rd_data)
  );

  bringup_pll_dom #(
    .SYNC_STAGES(SYNC_STAGES), .N_DCLK(N_DCLK)
  ) u_pll (
    .clk(clk), .arst_n(arst_n), .sys_rst(sys_rst), .pll_on(pll_on),
    .req_vld(req_vld), .req_on(req_on), .req_rel(req_rel), .pll_lock(pll_lock),
    .pll_pd(pll2_pd), .div_rst(div_rst), .dclk_en(dclk_en), .running(running),
    .lock_s(lock_s), .lock_err(lock_err)
  );

  assign dom_rst_n      = dom_rel;
  assign ext_rst_n      = ext_rel;
  assign proc_clk_full  = !clk_cfg[0];
  assign low_power      = clk_cfg[1];
  assign gpio_oe        = pad_ctl[N_GPIO-1:0];
  assign disp_en_oe     = pad_ctl[N_GPIO];
  assign disp_force_low = !pad_ctl[N_GPIO+1];

  assert_master_por_only_R2: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(master_pll_rst) |-> 1'b0);
  assert_ext_needs_proc_R3: assert property (@(posedge clk) disable iff (!arst_n)
    !proc_rst_n |=> (ext_rst_n == '0) || $past(proc_rst_n) == 1'b0 && $stable(ext_rst_n));

endmodule

// File: tb/tb_bringup_seq.sv
module tb_bringup_seq;
  logic       clk = 1'b0;
  logic       por_n = 1'b1;
  logic       pgood = 1'b1;
  logic       wdt_expire = 1'b0;
  logic       pll_lock = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       master_pll_rst, proc_rst_n, proc_clk_full, low_power;
  logic       pll2_pd, div_rst, disp_en_oe, disp_force_low;
  logic [3:0] dom_rst_n;
  logic [2:0] fe_clk_en, dclk_en;
  logic [1:0] ext_rst_n;
  logic [5:0] gpio_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  typedef struct { logic [7:0] exp; string tag; } exp_t;
  exp_t sb[$];
  logic rd_fire = 1'b0;
  logic fire_q  = 1'b0;

  always #2.5 clk = ~clk;

  bringup_seq dut (
    .clk(clk), .por_n(por_n), .pgood(pgood), .wdt_expire(wdt_expire),
    .pll_lock(pll_lock), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .master_pll_rst(master_pll_rst),
    .proc_rst_n(proc_rst_n), .dom_rst_n(dom_rst_n), .fe_clk_en(fe_clk_en),
    .proc_clk_full(proc_clk_full), .low_power(low_power), .pll2_pd(pll2_pd),
    .div_rst(div_rst), .dclk_en(dclk_en), .ext_rst_n(ext_rst_n),
    .gpio_oe(gpio_oe), .disp_en_oe(disp_en_oe), .disp_force_low(disp_force_low)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // Scoreboard: read data returns one clock after the address is presented.
  always @(posedge clk) fire_q <= rd_fire;
  always @(negedge clk) begin
    if (fire_q) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.tag, 32'(rd_data), 32'(e.exp));
    end
  end

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    exp_t e;
    @(negedge clk);
    rd_addr = a;
    rd_fire = 1'b1;
    e.exp = exp; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    rd_fire = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_defaults(input string why);
    chk({why, " R4 proc_clk_full"}, 32'(proc_clk_full), 32'd1);
    chk({why, " R4 low_power"}, 32'(low_power), 32'd0);
    chk({why, " R4 pll2_pd"}, 32'(pll2_pd), 32'd1);
    chk({why, " R4 div_rst"}, 32'(div_rst), 32'd1);
    chk({why, " R4 dclk_en"}, 32'(dclk_en), 32'd0);
    chk({why, " R5 gpio_oe"}, 32'(gpio_oe), 32'd0);
    chk({why, " R5 disp_en_oe"}, 32'(disp_en_oe), 32'd0);
    chk({why, " R5 disp_force_low"}, 32'(disp_force_low), 32'd1);
    chk({why, " R3 dom_rst_n"}, 32'(dom_rst_n), 32'd0);
    chk({why, " R3 ext_rst_n"}, 32'(ext_rst_n), 32'd0);
    chk({why, " R3 fe_clk_en"}, 32'(fe_clk_en), 32'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    #2 por_n = 1'b0;
    idle(5);
    chk("R1 master held in por", 32'(master_pll_rst), 32'd1);
    chk("R1 proc held in por", 32'(proc_rst_n), 32'd0);
    por_n = 1'b1;
    idle(1);
    chk("R1 master still held after por", 32'(master_pll_rst), 32'd1);
    chk_defaults("por");
    idle(20);
    chk("R1 master released", 32'(master_pll_rst), 32'd0);
    chk("R3 proc auto release", 32'(proc_rst_n), 32'd1);
    chk("R3 others still held", 32'(dom_rst_n), 32'd0);
    rd(3'd4, 8'h01, "R1 R11 cause power-up");

    // Divider release with PLL off: ignored, sticky error.
    wr(3'd0, 8'h02);
    chk("R8 release ignored", 32'(div_rst), 32'd1);
    rd(3'd4, 8'h09, "R8 sticky error set");
    // PLL on, divider still held.
    wr(3'd0, 8'h01);
    chk("R6 pll powered", 32'(pll2_pd), 32'd0);
    chk("R6 divider held", 32'(div_rst), 32'd1);
    wr(3'd0, 8'h03);
    chk("R8 release without lock ignored", 32'(div_rst), 32'd1);
    pll_lock = 1'b1;
    idle(4);
    wr(3'd0, 8'h03);
    chk("R7 divider released", 32'(div_rst), 32'd0);
    chk("R7 derived clocks on", 32'(dclk_en), 32'd7);
    rd(3'd0, 8'h03, "R7 running readback");
    rd(3'd4, 8'h19, "R8 R11 error sticky lock visible");

    // Lock drop while running.
    pll_lock = 1'b0;
    idle(SYNC_WAIT);
    chk("R9 clocks removed", 32'(dclk_en), 32'd0);
    chk("R9 divider reheld", 32'(div_rst), 32'd1);
    chk("R9 pll stays on", 32'(pll2_pd), 32'd0);
    pll_lock = 1'b1;
    idle(4);
    wr(3'd0, 8'h03);
    chk("R7 rerelease", 32'(dclk_en), 32'd7);

    // Register writes.
    wr(3'd1, 8'h0F);
    wr(3'd2, 8'h05);
    wr(3'd6, 8'hBF);
    wr(3'd5, 8'h03);
    wr(3'd3, 8'h03);
    chk("R10 dom_rst_n", 32'(dom_rst_n), 32'hF);
    chk("R10 fe_clk_en", 32'(fe_clk_en), 32'h5);
    chk("R10 ext_rst_n", 32'(ext_rst_n), 32'h3);
    chk("R10 proc_clk_full", 32'(proc_clk_full), 32'd0);
    chk("R10 low_power", 32'(low_power), 32'd1);
    chk("R10 gpio_oe", 32'(gpio_oe), 32'h3F);
    chk("R10 disp_en_oe", 32'(disp_en_oe), 32'd0);
    chk("R10 disp_force_low", 32'(disp_force_low), 32'd0);
    rd(3'd1, 8'h0F, "R10 dom readback");
    rd(3'd6, 8'hBF, "R10 pad readback");
    rd(3'd5, 8'h03, "R10 clk readback");

    // Watchdog pulse.
    @(negedge clk);
    wdt_expire = 1'b1;
    @(negedge clk);
    wdt_expire = 1'b0;
    chk("R2 wdt no master reset", 32'(master_pll_rst), 32'd0);
    chk("R2 wdt proc held", 32'(proc_rst_n), 32'd0);
    chk_defaults("R2 wdt");
    idle(10);
    chk("R3 proc released after wdt", 32'(proc_rst_n), 32'd1);
    rd(3'd4, 8'h14, "R11 cause watchdog, error cleared");

    // Power-good loss, plus a write while the processor is still held.
    pgood = 1'b0;
    idle(4);
    chk("R2 pgood no master reset", 32'(master_pll_rst), 32'd0);
    chk("R2 pgood proc held", 32'(proc_rst_n), 32'd0);
    pgood = 1'b1;
    idle(2);
    wr(3'd1, 8'h0F);
    chk("R10 proc still held during write", 32'(proc_rst_n), 32'd0);
    idle(10);
    chk("R10 write in reset ignored", 32'(dom_rst_n), 32'd0);
    rd(3'd1, 8'h00, "R10 dom readback after ignored write");
    rd(3'd4, 8'h12, "R11 cause power-good");

    // Watchdog together with power-good loss: power-good wins.
    pgood = 1'b0;
    idle(4);
    @(negedge clk);
    wdt_expire = 1'b1;
    @(negedge clk);
    wdt_expire = 1'b0;
    pgood = 1'b1;
    idle(12);
    rd(3'd4, 8'h12, "R11 power-good outranks watchdog");

    // Fresh power-up.
    pll_lock = 1'b0;
    idle(4);
    @(negedge clk);
    por_n = 1'b0;
    idle(2);
    chk("R1 master on repeat por", 32'(master_pll_rst), 32'd1);
    por_n = 1'b1;
    idle(20);
    rd(3'd4, 8'h01, "R1 cause power-up again");
    idle(3);
    finish_run();
  end

  localparam int SYNC_WAIT = 4;

endmodule